// File: doc/BRIEF.md
# Paged Memory Write Controller

This block holds a 512-byte store in on-chip registers, split into two independently selected banks of 256 bytes. A host front end, with its bit-level serial framing stripped away, talks to it through pulse commands. It opens a write burst or a read session by naming a bank and a starting byte address. It then streams bytes in or pulls bytes out, and closes a write burst with an end strobe.

Write bursts are confined to one 8-byte page. Incoming bytes are gathered in a small page buffer, and only the low three address bits advance. When a burst runs past the last byte of its page, it wraps to the first byte of that same page and overwrites what was staged there. The burst never spills into the next page. When the end strobe arrives, only the staged bytes are copied into the store, and a busy flag then models the programming time. Any new command issued while the flag is high is refused. Reads are not limited to a page: the pointer walks the whole bank and rolls over from FFh to 00h.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset, `busy`, `req_ack`, `req_nack` and `rd_valid` are 0, and every byte of both banks reads back as 00h.
- R2: A byte's physical location is the bank select taken as the top bit, followed by the 8-bit byte address. The two banks hold separate contents.
- R3: During a write burst, byte k of the burst lands at page offset (start offset + k) mod 8. The upper five address bits stay fixed. No byte outside that page changes.
- R4: If more than 8 bytes arrive in one burst, the last byte sent to each page offset is the value committed there.
- R5: Bytes of the page that the burst did not write keep their earlier contents after the commit.
- R6: An end strobe while a burst is open commits the buffer. `busy` then reads 1 from the cycle after the strobe, for exactly BUSY_CYCLES cycles.
- R7: A start request is answered one cycle later. If `busy` was low, `req_ack` pulses. If `busy` was high, `req_nack` pulses and the request has no other effect.
- R8: A byte strobe or read strobe that does not match the open session has no effect on the store. This includes strobes given while busy or with no session open. A read strobe outside a read session produces no `rd_valid`.
- R9: In a read session, each `rd_byte` yields `rd_data` with `rd_valid` one cycle later and advances the 8-bit address. The address rolls from FFh to 00h within the same bank.
- R10: When `wr_start` and `rd_start` are raised in the same cycle, a write burst opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Open a write burst at `blk_sel`/`word_addr` |
| rd_start | input | 1 | Open a read session at `blk_sel`/`word_addr` |
| blk_sel | input | BLK_W (1) | Bank select, top bit of the physical address |
| word_addr | input | ADDR_W (8) | Starting byte address within the bank |
| wr_byte | input | 1 | Stage `wr_data` at the current page offset |
| wr_data | input | DATA_W (8) | Byte to stage |
| wr_end | input | 1 | Close the burst and commit the page buffer |
| rd_byte | input | 1 | Fetch the byte at the read pointer |
| rd_data | output | DATA_W (8) | Fetched byte |
| rd_valid | output | 1 | `rd_data` holds a fresh byte this cycle |
| req_ack | output | 1 | Previous-cycle start was accepted |
| req_nack | output | 1 | Previous-cycle start was refused |
| busy | output | 1 | Modelled programming time in progress |

## Verification
The bench keeps the default geometry: two banks of 256 bytes and 8-byte pages. This keeps full-store compares against a reference array cheap, and the page wrap, the bank rollover and the bank split all fall on small addresses. BUSY_CYCLES is lowered to 12. That makes the busy window short enough to measure exactly after every burst, while it stays long enough to fire refused starts and stray strobes into it.

// File: rtl/pgmem_pkg.sv
`timescale 1ns/1ps
package pgmem_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_WRITE = 2'd1,
      MODE_READ  = 2'd2
   } pgm_mode_e;
endpackage

// File: rtl/pgmem_stage.sv
`timescale 1ns/1ps
module pgmem_stage #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         load,
   input  logic [OFS_W-1:0]             slot,
   input  logic [DATA_W-1:0]            din,
   output logic [PAGE_BYTES-1:0]        vld,
   output logic [PAGE_BYTES*DATA_W-1:0] bytes_flat
);
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clear) begin
            v_q <= 1'b0;
         end else if (load && slot == OFS_W'(g)) begin
            v_q <= 1'b1;
            d_q <= din;
         end
      end
      assign vld[g]                      = v_q;
      assign bytes_flat[g*DATA_W +: DATA_W] = d_q;
   end
endmodule

// File: rtl/pgmem_array.sv
`timescale 1ns/1ps
module pgmem_array #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int DEPTH      = 512,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int PHYS_W    = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic [PHYS_W-OFS_W-1:0]      page_sel,
   input  logic [PAGE_BYTES-1:0]        vld,
   input  logic [PAGE_BYTES*DATA_W-1:0] bytes_flat,
   input  logic                         rd_en,
   input  logic [PHYS_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_valid
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (commit) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
               if (vld[s]) mem[{page_sel, OFS_W'(s)}] <= bytes_flat[s*DATA_W +: DATA_W];
            end
         end
         rd_valid <= rd_en;
         if (rd_en) rd_data <= mem[rd_addr];
      end
   end
endmodule

// File: rtl/pgmem_busy.sv
`timescale 1ns/1ps
module pgmem_busy #(
   parameter int BUSY_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   if (BUSY_CYCLES == 0) begin : g_none
      logic unused_load;
      logic unused_clk;
      logic unused_rst;
      assign unused_load = load;
      assign unused_clk  = clk;
      assign unused_rst  = rst_n;
      assign busy        = 1'b0;
   end else begin : g_timer
      localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)          cnt <= '0;
         else if (load)       cnt <= CNT_W'(BUSY_CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
   end
endmodule

// File: rtl/pgmem_ctrl.sv
`timescale 1ns/1ps
module pgmem_ctrl #(
   parameter int DATA_W          = 8,
   parameter int BLOCKS          = 2,
   parameter int WORDS_PER_BLOCK = 256,
   parameter int PAGE_BYTES      = 8,
   parameter int BUSY_CYCLES     = 64,
   localparam int BLK_W          = $clog2(BLOCKS),
   localparam int ADDR_W         = $clog2(WORDS_PER_BLOCK),
   localparam int OFS_W          = $clog2(PAGE_BYTES),
   localparam int DEPTH          = BLOCKS * WORDS_PER_BLOCK,
   localparam int PHYS_W         = BLK_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic [BLK_W-1:0]  blk_sel,
   input  logic [ADDR_W-1:0] word_addr,
   input  logic              wr_byte,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_end,
   input  logic              rd_byte,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              req_ack,
   output logic              req_nack,
   output logic              busy
);
   import pgmem_pkg::*;

   if (BLOCKS < 2 || (BLOCKS & (BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("BLOCKS must be a power of two of at least 2");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (WORDS_PER_BLOCK <= PAGE_BYTES || (WORDS_PER_BLOCK & (WORDS_PER_BLOCK - 1)) != 0) begin : g_bad_words
      $error("WORDS_PER_BLOCK must be a power of two above PAGE_BYTES");
   end
   if (BUSY_CYCLES < 0) begin : g_bad_busy
      $error("BUSY_CYCLES must not be negative");
   end

   pgm_mode_e         mode;
   logic [BLK_W-1:0]  ptr_blk;
   logic [ADDR_W-1:0] ptr_addr;

   logic start_any, start_ok, stage_load, commit, rd_en;
   logic [PAGE_BYTES-1:0]        stg_vld;
   logic [PAGE_BYTES*DATA_W-1:0] stg_bytes;

   assign start_any  = wr_start | rd_start;
   assign start_ok   = start_any & ~busy;
   assign commit     = (mode == MODE_WRITE) & ~start_any & wr_end;
   assign stage_load = (mode == MODE_WRITE) & ~start_any & ~wr_end & wr_byte;
   assign rd_en      = (mode == MODE_READ) & ~start_any & ~busy & rd_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= MODE_IDLE;
         ptr_blk  <= '0;
         ptr_addr <= '0;
         req_ack  <= 1'b0;
         req_nack <= 1'b0;
      end else begin
         req_ack  <= start_ok;
         req_nack <= start_any & busy;
         if (start_ok) begin
            mode     <= wr_start ? MODE_WRITE : MODE_READ;
            ptr_blk  <= blk_sel;
            ptr_addr <= word_addr;
         end else if (stage_load) begin
            ptr_addr <= {ptr_addr[ADDR_W-1:OFS_W], ptr_addr[OFS_W-1:0] + OFS_W'(1)};
         end else if (commit) begin
            mode <= MODE_IDLE;
         end else if (rd_en) begin
            ptr_addr <= ptr_addr + ADDR_W'(1);
         end
      end
   end

   pgmem_stage #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start_ok & wr_start),
      .load       (stage_load),
      .slot       (ptr_addr[OFS_W-1:0]),
      .din        (wr_data),
      .vld        (stg_vld),
      .bytes_flat (stg_bytes)
   );

   pgmem_array #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .DEPTH(DEPTH)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .page_sel   ({ptr_blk, ptr_addr[ADDR_W-1:OFS_W]}),
      .vld        (stg_vld),
      .bytes_flat (stg_bytes),
      .rd_en      (rd_en),
      .rd_addr    ({ptr_blk, ptr_addr}),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid)
   );

   pgmem_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (commit),
      .busy  (busy)
   );
endmodule

// File: rtl/pgmem_ctrl_chk.sv
`timescale 1ns/1ps
module pgmem_ctrl_chk #(
   parameter int BUSY_CYCLES = 64,
   parameter int PAGE_W      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_start,
   input logic              rd_start,
   input logic              rd_byte,
   input logic              busy,
   input logic              req_ack,
   input logic              req_nack,
   input logic              rd_valid,
   input logic              commit,
   input logic              in_write,
   input logic [PAGE_W-1:0] page_bits
);
   int busy_run;
   always_ff @(posedge clk) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   if (BUSY_CYCLES > 0) begin : g_commit_chk
      assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
         commit |=> busy);
   end

   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_run < BUSY_CYCLES);

   assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_start || rd_start) && busy) |=> (req_nack && !req_ack));

   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_start || rd_start) && !busy) |=> (req_ack && !req_nack));

   assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_write && !wr_start && !rd_start) |=> $stable(page_bits));

   assert_read_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_byte));

   assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid);
endmodule

bind pgmem_ctrl pgmem_ctrl_chk #(
   .BUSY_CYCLES (BUSY_CYCLES),
   .PAGE_W      (ADDR_W - OFS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_start  (wr_start),
   .rd_start  (rd_start),
   .rd_byte   (rd_byte),
   .busy      (busy),
   .req_ack   (req_ack),
   .req_nack  (req_nack),
   .rd_valid  (rd_valid),
   .commit    (commit),
   .in_write  (mode == pgmem_pkg::MODE_WRITE),
   .page_bits (ptr_addr[ADDR_W-1:OFS_W])
);

// File: tb/sim_pgmem_ctrl.sv
`timescale 1ns/1ps
module sim_pgmem_ctrl;
   localparam int NBUSY = 12;
   localparam int NVEC  = 6;
   // vector: bank(1) | start address(8) | byte count(5) | first data byte(8)
   localparam logic [21:0] VECS [NVEC] = '{
      {1'b0, 8'h05, 5'd6,  8'h10},
      {1'b1, 8'h05, 5'd3,  8'h40},
      {1'b0, 8'hFA, 5'd11, 8'h80},
      {1'b0, 8'h00, 5'd2,  8'hC0},
      {1'b1, 8'hFF, 5'd1,  8'hE0},
      {1'b1, 8'h13, 5'd16, 8'h20}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start = 1'b0, rd_start = 1'b0, wr_byte = 1'b0, wr_end = 1'b0, rd_byte = 1'b0;
   logic [0:0] blk_sel = '0;
   logic [7:0] word_addr = '0, wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_valid, req_ack, req_nack, busy;

   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;
   logic [7:0] ref_mem [512];

   always #2.5 clk = ~clk;

   pgmem_ctrl #(.BUSY_CYCLES(NBUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
      .blk_sel(blk_sel), .word_addr(word_addr), .wr_byte(wr_byte), .wr_data(wr_data),
      .wr_end(wr_end), .rd_byte(rd_byte), .rd_data(rd_data), .rd_valid(rd_valid),
      .req_ack(req_ack), .req_nack(req_nack), .busy(busy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic start_req(input bit wr, input bit rd, input logic b, input logic [7:0] a,
                            input bit exp_ack, input string tag);
      wr_start = wr; rd_start = rd; blk_sel = b; word_addr = a;
      @(negedge clk);
      wr_start = 1'b0; rd_start = 1'b0;
      check(req_ack == exp_ack && req_nack == !exp_ack, tag, {req_ack, req_nack}, {exp_ack, !exp_ack});
   endtask

   task automatic send_byte(input logic [7:0] d);
      wr_byte = 1'b1; wr_data = d;
      @(negedge clk);
      wr_byte = 1'b0;
   endtask

   task automatic close_burst(output int seen);
      wr_end = 1'b1;
      @(negedge clk);
      wr_end = 1'b0;
      seen = 0;
      while (busy) begin
         seen++;
         @(negedge clk);
      end
   endtask

   task automatic read_bank(input logic b, input string tag);
      int bad = 0;
      int first_act = 0, first_exp = 0;
      start_req(1'b0, 1'b1, b, 8'h00, 1'b1, "R7 read start ack");
      rd_byte = 1'b1;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (!rd_valid || rd_data !== ref_mem[{b, 8'(k)}]) begin
            if (bad == 0) begin first_act = rd_data; first_exp = ref_mem[{b, 8'(k)}]; end
            bad++;
         end
      end
      rd_byte = 1'b0;
      check(bad == 0, tag, first_act, first_exp);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset, store cleared
      check(!busy && !req_ack && !req_nack && !rd_valid, "R1 reset outputs",
            {busy, req_ack, req_nack, rd_valid}, 0);
      read_bank(1'b0, "R1 bank 0 clear");
      read_bank(1'b1, "R1 bank 1 clear");

      // Vector table: bursts from mid-page and across the page end (R2 R3 R4 R5 R6)
      for (int v = 0; v < NVEC; v++) begin
         logic       vb;
         logic [7:0] va, vd;
         int         vn, seen;
         {vb, va, vn, vd} = {VECS[v][21], VECS[v][20:13], 32'(VECS[v][12:8]), VECS[v][7:0]};
         start_req(1'b1, 1'b0, vb, va, 1'b1, "R7 write start ack");
         for (int i = 0; i < vn; i++) begin
            logic [7:0] d = vd + 8'(i);
            send_byte(d);
            ref_mem[{vb, va[7:3], 3'(va[2:0] + 3'(i))}] = d;
         end
         close_burst(seen);
         check(seen == NBUSY, "R6 busy length", seen, NBUSY);
         read_bank(1'b0, "R3 R4 R5 bank 0 contents");
         read_bank(1'b1, "R2 R3 R5 bank 1 contents");
      end

      // Directed: refusal and stray strobes while busy (R7 R8)
      begin
         int seen;
         start_req(1'b1, 1'b0, 1'b0, 8'h21, 1'b1, "R7 write start ack");
         rd_byte = 1'b1;                     // R8: read strobe inside a write burst
         @(negedge clk);
         rd_byte = 1'b0;
         check(!rd_valid, "R8 read strobe in write burst", rd_valid, 0);
         send_byte(8'h3C);
         ref_mem[{1'b0, 8'h21}] = 8'h3C;
         wr_end = 1'b1;
         @(negedge clk);
         wr_end = 1'b0;
         check(busy, "R6 busy after commit", busy, 1);
         start_req(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R7 read refused while busy");
         start_req(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R7 write refused while busy");
         rd_byte = 1'b1;
         @(negedge clk);
         rd_byte = 1'b0;
         check(!rd_valid, "R8 read strobe while busy", rd_valid, 0);
         send_byte(8'hAA);                   // R8: must not land anywhere
         wr_end = 1'b1;
         @(negedge clk);
         wr_end = 1'b0;
         seen = 0;
         while (busy) @(negedge clk);
         read_bank(1'b0, "R8 bank 0 untouched by stray strobes");
         read_bank(1'b1, "R8 bank 1 untouched by stray strobes");
      end

      // Directed: both starts together open a write (R10)
      begin
         int seen;
         start_req(1'b1, 1'b1, 1'b1, 8'h40, 1'b1, "R10 dual start ack");
         send_byte(8'h5A);
         ref_mem[{1'b1, 8'h40}] = 8'h5A;
         close_burst(seen);
         check(seen == NBUSY, "R10 write opened, busy length", seen, NBUSY);
         read_bank(1'b1, "R10 bank 1 write landed");
      end

      // Directed: read rollover FFh -> 00h within bank 1 (R9)
      start_req(1'b0, 1'b1, 1'b1, 8'hFE, 1'b1, "R9 read start ack");
      rd_byte = 1'b1;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] a = 8'hFE + 8'(k);
         @(negedge clk);
         check(rd_valid && rd_data === ref_mem[{1'b1, a}], "R9 rollover read",
               rd_data, ref_mem[{1'b1, a}]);
      end
      rd_byte = 1'b0;
      @(negedge clk);
      check(!rd_valid, "R9 no data without strobe", rd_valid, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule